// File: doc/BRIEF.md
# Acquire/Release Cache Maintenance Sequencer

This block sits in front of a GPU level-one data cache and enforces acquire/release ordering for the memory requests that reach it. Each request carries a kind code and a context number. Acquire-type requests start a walk over every block index of the cache, issuing one invalidate command per index. Release-type requests start a similar walk that issues flush commands. Commands leave one per clock over a valid/ready interface toward the cache's mandatory request queue.

Two counters track the invalidations and writebacks still owed by the cache controller. The controller retires them through one-cycle done strobes. While any writeback is outstanding, ordinary traffic is held off. Kernel-end requests are parked in a small in-order queue. Each one is reported complete, one context per cycle, once the writeback count has drained to zero and no walk is running. Each completion strobe from the controller is answered one cycle later by a retry pulse, which tells upstream logic to resend held requests.

Top module: `acqrel_sequencer`

## Requirements
- R1: After reset `cmdValid`, `kdoneValid` and `retryPulse` are low, both outstanding counts are zero, and the walk index is zero.
- R2: An accepted release (kind 2) drives `cmdValid` with `cmdOp`=1 (flush) for indices 0 to NBLK-1 in rising order, one index per accepted handshake. Each accepted flush raises `wbCount` by one.
- R3: An accepted acquire (kind 1) walks indices 0 to NBLK-1 with `cmdOp`=0 (invalidate). Each accepted invalidate raises `invCount` by one, and nothing waits on these.
- R4: An accepted acquire-release (kind 3) issues the whole invalidate walk first and then the whole flush walk, with no gap between them.
- R5: While `cmdValid` is high and `cmdReady` is low, `cmdIndex` and `cmdOp` hold their values.
- R6: Plain requests (kind 0, and the unused codes 6 and 7), acquires, releases and acquire-releases are not accepted while `wbCount` is non-zero. Plain requests are also not accepted while a flush walk runs. Kernel-begin (kind 4) and kernel-end (kind 5) requests remain acceptable during a writeback drain.
- R7: Kinds 1 to 5 are back-pressured (`reqReady` low) while any walk is still issuing.
- R8: A kernel-end appends its context number to an in-order pending queue. It starts a flush walk only if `wbCount` is zero when it is accepted. Pending contexts leave on `kdoneCtx` with `kdoneValid`, one per cycle in arrival order, whenever `wbCount` is zero and no walk is running.
- R9: A kernel-begin starts an invalidate walk unless writebacks and invalidations are both outstanding. In that case it is accepted and starts nothing.
- R10: `wbDone` lowers `wbCount` by one and `invDone` lowers `invCount` by one. A strobe that arrives while its count is zero has no effect.
- R11: `retryPulse` is high for exactly the cycle after any cycle in which `wbDone` or `invDone` was high.
- R12: Kinds 1, 3 and 4 are refused while `invCount` exceeds NBLK. A kernel-end is refused while the pending queue holds KE_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when valid |
| reqKind | input | 3 | 0 plain, 1 acquire, 2 release, 3 acquire-release, 4 kernel-begin, 5 kernel-end, 6/7 plain |
| reqCtx | input | CTX_W | Context number of the request |
| cmdValid | output | 1 | Maintenance command present |
| cmdReady | input | 1 | Request queue takes the command |
| cmdOp | output | 1 | 0 invalidate, 1 flush |
| cmdIndex | output | $clog2(NBLK) | Cache block index of the command |
| wbDone | input | 1 | One writeback retired |
| invDone | input | 1 | One invalidation retired |
| retryPulse | output | 1 | Resend strobe after a completion |
| kdoneValid | output | 1 | A pending kernel end completes |
| kdoneCtx | output | CTX_W | Context of the completing kernel end |
| wbCount | output | $clog2(2*NBLK+1) | Outstanding writebacks |
| invCount | output | $clog2(2*NBLK+1) | Outstanding invalidations |

## Verification
The bench drives a walk with `cmdReady` toggling. A design that advanced its index on valid alone would skip indices or lose flush counts. It sends kernel-begin requests during a drain both with and without invalidations outstanding, where a wrong gate either starts a stray walk or drops the needed one. It sends surplus `wbDone` strobes after the count reaches zero, which a design without the floor would wrap to the maximum and stall forever. Randomised traffic then fills the kernel-end queue and mixes push and pop in one cycle, which would expose an ordering fault or a lost context.

// File: rtl/acqrel_pkg.sv
package acqrel_pkg;

  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_ACQ    = 3'd1,
    K_REL    = 3'd2,
    K_ACQREL = 3'd3,
    K_KBEGIN = 3'd4,
    K_KEND   = 3'd5
  } reqKind_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_INV   = 2'd1,
    W_FLUSH = 2'd2
  } walkPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;       // a command handshake completed
    logic stepFlush;  // that command was a flush
    logic pushKe;     // queue a kernel-end context
    logic popKe;      // retire the head kernel-end context
  } seqStrobes_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import acqrel_pkg::*;
#(
  parameter int NBLK  = 64,
  parameter int CNT_W = $clog2(2*NBLK+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqKind,
  input  logic             cmdReady,
  input  logic             idxLast,
  input  logic             wbZero,
  input  logic             invZero,
  input  logic [CNT_W-1:0] invCount,
  input  logic             keFull,
  input  logic             keEmpty,
  output logic             reqReady,
  output logic             cmdValid,
  output logic             cmdOp,
  output logic             kdoneValid,
  output seqStrobes_t      strb
);

  walkPhase_e phase;
  logic       chainFlush;
  reqKind_e   kind;
  logic       busy, invRoom, accept, startInv, startFlush, fire;

  assign kind    = reqKind_e'(reqKind);
  assign busy    = (phase != W_IDLE);
  assign invRoom = (invCount <= CNT_W'(NBLK));

  always_comb begin
    case (kind)
      K_ACQ, K_ACQREL: reqReady = !busy && wbZero && invRoom;
      K_REL:           reqReady = !busy && wbZero;
      K_KBEGIN:        reqReady = !busy && invRoom;
      K_KEND:          reqReady = !busy && !keFull;
      default:         reqReady = wbZero && (phase != W_FLUSH);
    endcase
  end

  assign accept     = reqValid && reqReady;
  assign startInv   = accept && ((kind == K_ACQ) || (kind == K_ACQREL) ||
                                 ((kind == K_KBEGIN) && (wbZero || invZero)));
  assign startFlush = accept && ((kind == K_REL) || ((kind == K_KEND) && wbZero));

  assign cmdValid   = busy;
  assign cmdOp      = (phase == W_FLUSH);
  assign fire       = cmdValid && cmdReady;
  assign kdoneValid = !keEmpty && wbZero && !busy;

  always_comb begin
    strb.step      = fire;
    strb.stepFlush = (phase == W_FLUSH);
    strb.pushKe    = accept && (kind == K_KEND);
    strb.popKe     = kdoneValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= W_IDLE;
      chainFlush <= 1'b0;
    end else begin
      case (phase)
        W_IDLE: begin
          if (startInv) begin
            phase      <= W_INV;
            chainFlush <= (kind == K_ACQREL);
          end else if (startFlush) begin
            phase <= W_FLUSH;
          end
        end
        W_INV: begin
          if (fire && idxLast) begin
            phase      <= chainFlush ? W_FLUSH : W_IDLE;
            chainFlush <= 1'b0;
          end
        end
        W_FLUSH: begin
          if (fire && idxLast) phase <= W_IDLE;
        end
        default: phase <= W_IDLE;
      endcase
    end
  end

  // R4
  chain_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == W_INV) && chainFlush && fire && idxLast |=> cmdValid && cmdOp);

  // R6
  drain_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wbZero && reqValid && reqReady |-> (kind == K_KBEGIN) || (kind == K_KEND));

  // R7
  walk_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && reqValid && reqReady |-> !(reqKind inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}));

  // R12
  inv_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invCount > CNT_W'(NBLK)) && reqValid && reqReady |-> !(reqKind inside {3'd1, 3'd3, 3'd4}));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import acqrel_pkg::*;
#(
  parameter int NBLK     = 64,
  parameter int CTX_W    = 4,
  parameter int KE_DEPTH = 4,
  parameter int IDX_W    = $clog2(NBLK),
  parameter int CNT_W    = $clog2(2*NBLK+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [CTX_W-1:0] reqCtx,
  input  logic             wbDone,
  input  logic             invDone,
  output logic [IDX_W-1:0] cmdIndex,
  output logic             idxLast,
  output logic [CNT_W-1:0] wbCount,
  output logic [CNT_W-1:0] invCount,
  output logic             wbZero,
  output logic             invZero,
  output logic             keFull,
  output logic             keEmpty,
  output logic [CTX_W-1:0] kdoneCtx,
  output logic             retryPulse
);

  localparam int PTR_W  = (KE_DEPTH > 1) ? $clog2(KE_DEPTH) : 1;
  localparam int FILL_W = $clog2(KE_DEPTH + 1);

  logic [IDX_W-1:0]  idx;
  logic              wbInc, wbDec, invInc, invDec;
  logic [CTX_W-1:0]  keMem [KE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [FILL_W-1:0] fill;

  assign cmdIndex = idx;
  assign idxLast  = (idx == IDX_W'(NBLK - 1));
  assign wbZero   = (wbCount == '0);
  assign invZero  = (invCount == '0);
  assign wbInc    = strb.step && strb.stepFlush;
  assign invInc   = strb.step && !strb.stepFlush;
  assign wbDec    = wbDone && !wbZero;
  assign invDec   = invDone && !invZero;
  assign keFull   = (fill == FILL_W'(KE_DEPTH));
  assign keEmpty  = (fill == '0);
  assign kdoneCtx = keMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx        <= '0;
      wbCount    <= '0;
      invCount   <= '0;
      retryPulse <= 1'b0;
    end else begin
      if (strb.step) idx <= idxLast ? '0 : idx + IDX_W'(1);
      wbCount    <= wbCount + CNT_W'(wbInc) - CNT_W'(wbDec);
      invCount   <= invCount + CNT_W'(invInc) - CNT_W'(invDec);
      retryPulse <= wbDone || invDone;
    end
  end

  // pending kernel-end storage, one register per slot
  for (genvar g = 0; g < KE_DEPTH; g++) begin : g_keSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) keMem[g] <= '0;
      else if (strb.pushKe && (wrPtr == PTR_W'(g))) keMem[g] <= reqCtx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strb.pushKe) wrPtr <= (wrPtr == PTR_W'(KE_DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (strb.popKe)  rdPtr <= (rdPtr == PTR_W'(KE_DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      fill <= fill + FILL_W'(strb.pushKe) - FILL_W'(strb.popKe);
    end
  end

  // R10
  wb_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbDone && wbZero && !wbInc |=> wbZero);

  // R2
  wb_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbInc && !wbDone |=> wbCount == $past(wbCount) + CNT_W'(1));

  // R8
  ke_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pushKe && keFull && !strb.popKe));

  // R11
  retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbDone || invDone |=> retryPulse);

endmodule

// File: rtl/acqrel_sequencer.sv
module acqrel_sequencer
  import acqrel_pkg::*;
#(
  parameter int NBLK     = 64,
  parameter int CTX_W    = 4,
  parameter int KE_DEPTH = 4,
  parameter int IDX_W    = $clog2(NBLK),
  parameter int CNT_W    = $clog2(2*NBLK+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqKind,
  input  logic [CTX_W-1:0] reqCtx,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic             cmdOp,
  output logic [IDX_W-1:0] cmdIndex,
  input  logic             wbDone,
  input  logic             invDone,
  output logic             retryPulse,
  output logic             kdoneValid,
  output logic [CTX_W-1:0] kdoneCtx,
  output logic [CNT_W-1:0] wbCount,
  output logic [CNT_W-1:0] invCount
);

  seqStrobes_t strb;
  logic idxLast, wbZero, invZero, keFull, keEmpty;

  seq_ctrl #(.NBLK(NBLK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .cmdReady(cmdReady), .idxLast(idxLast), .wbZero(wbZero), .invZero(invZero),
    .invCount(invCount), .keFull(keFull), .keEmpty(keEmpty),
    .reqReady(reqReady), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .kdoneValid(kdoneValid), .strb(strb)
  );

  seq_datapath #(.NBLK(NBLK), .CTX_W(CTX_W), .KE_DEPTH(KE_DEPTH),
                 .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCtx(reqCtx),
    .wbDone(wbDone), .invDone(invDone), .cmdIndex(cmdIndex), .idxLast(idxLast),
    .wbCount(wbCount), .invCount(invCount), .wbZero(wbZero), .invZero(invZero),
    .keFull(keFull), .keEmpty(keEmpty), .kdoneCtx(kdoneCtx), .retryPulse(retryPulse)
  );

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdIndex) && $stable(cmdOp));

  // R8
  kdone_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    kdoneValid |-> (wbCount == '0) && !cmdValid);

endmodule

// File: tb/sim_acqrel_sequencer.sv
`timescale 1ns/1ps
module sim_acqrel_sequencer;

  localparam int NBLK  = 8;
  localparam int CTX_W = 4;
  localparam int KED   = 4;
  localparam int IDX_W = $clog2(NBLK);
  localparam int CNT_W = $clog2(2*NBLK+1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, cmdReady = 1'b1, wbDone = 1'b0, invDone = 1'b0;
  logic [2:0] reqKind = 3'd0;
  logic [CTX_W-1:0] reqCtx = '0;
  logic reqReady, cmdValid, cmdOp, retryPulse, kdoneValid;
  logic [IDX_W-1:0] cmdIndex;
  logic [CTX_W-1:0] kdoneCtx;
  logic [CNT_W-1:0] wbCount, invCount;

  always #2.5 clk = ~clk;

  acqrel_sequencer #(.NBLK(NBLK), .CTX_W(CTX_W), .KE_DEPTH(KED)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqCtx(reqCtx), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdIndex(cmdIndex), .wbDone(wbDone), .invDone(invDone),
    .retryPulse(retryPulse), .kdoneValid(kdoneValid), .kdoneCtx(kdoneCtx),
    .wbCount(wbCount), .invCount(invCount)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference model state
  int mWb = 0, mInv = 0, mIdx = 0, mPhase = 0, mChain = 0, mRetry = 0;
  int mQ[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit expReady(input int kind);
    bit busy = (mPhase != 0);
    bit room = (mInv <= NBLK);
    case (kind)
      1, 3: return !busy && mWb == 0 && room;
      2:    return !busy && mWb == 0;
      4:    return !busy && room;
      5:    return !busy && mQ.size() < KED;
      default: return mWb == 0 && mPhase != 2;
    endcase
  endfunction

  function automatic string readyTag(input int kind);
    case (kind)
      4: return "R9";
      5: return (mQ.size() >= KED) ? "R12" : "R8";
      1, 3: return (mInv > NBLK) ? "R12" : "R7";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  // one clock: compare at negedge+1, advance model, move to next negedge
  task automatic step();
    bit eReady, eCmdV, eKv, fire, acc;
    int k, nWb, nInv;
    #1;
    k = int'(reqKind);
    eReady = expReady(k);
    eCmdV  = (mPhase != 0);
    eKv    = (mQ.size() > 0) && mWb == 0 && mPhase == 0;
    chk(reqReady == eReady, readyTag(k), "reqReady", reqReady, eReady);
    chk(cmdValid == eCmdV, "R2", "cmdValid", cmdValid, eCmdV);
    if (eCmdV) begin
      chk(cmdOp == (mPhase == 2), "R4", "cmdOp", cmdOp, mPhase == 2);
      chk(int'(cmdIndex) == mIdx, "R5", "cmdIndex", cmdIndex, mIdx);
    end
    chk(int'(wbCount) == mWb, "R10", "wbCount", wbCount, mWb);
    chk(int'(invCount) == mInv, "R3", "invCount", invCount, mInv);
    chk(retryPulse == mRetry[0], "R11", "retryPulse", retryPulse, mRetry);
    chk(kdoneValid == eKv, "R8", "kdoneValid", kdoneValid, eKv);
    if (eKv) chk(int'(kdoneCtx) == mQ[0], "R8", "kdoneCtx", kdoneCtx, mQ[0]);

    fire = eCmdV && cmdReady;
    acc  = reqValid && eReady;
    nWb  = mWb + ((fire && mPhase == 2) ? 1 : 0) - ((wbDone && mWb > 0) ? 1 : 0);
    nInv = mInv + ((fire && mPhase == 1) ? 1 : 0) - ((invDone && mInv > 0) ? 1 : 0);
    if (eKv) void'(mQ.pop_front());
    if (acc && k == 5) mQ.push_back(int'(reqCtx));
    if (mPhase != 0) begin
      if (fire) begin
        if (mIdx == NBLK - 1) begin
          mIdx = 0;
          if (mPhase == 1 && mChain == 1) begin mPhase = 2; mChain = 0; end
          else mPhase = 0;
        end else mIdx++;
      end
    end else if (acc) begin
      case (k)
        1: begin mPhase = 1; mChain = 0; end
        3: begin mPhase = 1; mChain = 1; end
        4: if (mWb == 0 || mInv == 0) begin mPhase = 1; mChain = 0; end
        2: mPhase = 2;
        5: if (mWb == 0) mPhase = 2;
        default: ;
      endcase
    end
    mWb = nWb;
    mInv = nInv;
    mRetry = (wbDone || invDone) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendReq(input int kind, input int ctx);
    bit acc;
    reqValid = 1'b1;
    reqKind  = 3'(kind);
    reqCtx   = CTX_W'(ctx);
    for (int i = 0; i < 300; i++) begin
      acc = expReady(kind);
      step();
      if (acc) break;
    end
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(cmdValid == 1'b0, "R1", "cmdValid", cmdValid, 0);
    chk(kdoneValid == 1'b0, "R1", "kdoneValid", kdoneValid, 0);
    chk(retryPulse == 1'b0, "R1", "retryPulse", retryPulse, 0);
    chk(wbCount == '0 && invCount == '0, "R1", "counts", int'(wbCount) + int'(invCount), 0);
    chk(cmdIndex == '0, "R1", "cmdIndex", cmdIndex, 0);
    @(negedge clk);

    sendReq(0, 0);                       // R6 plain with nothing pending
    // R2 R5 release walk under a stuttering ready
    reqValid = 1'b1; reqKind = 3'd2; reqCtx = '0;
    step();
    reqValid = 1'b0;
    for (int i = 0; i < 3*NBLK; i++) begin
      cmdReady = (i % 3 != 0);
      step();
    end
    cmdReady = 1'b1;
    // R6 plain and acquire refused during drain
    reqValid = 1'b1; reqKind = 3'd0; idle(3);
    reqKind = 3'd1; idle(3);
    reqValid = 1'b0;
    sendReq(5, 3);                       // R8 queued, no walk
    sendReq(4, 0);                       // R9 invalidations zero: walk
    idle(NBLK + 2);
    sendReq(4, 0);                       // R9 both outstanding: no walk
    idle(2);
    sendReq(5, 7);
    // R10 R11 drain writebacks with surplus strobes
    wbDone = 1'b1; idle(NBLK + 3); wbDone = 1'b0;
    idle(3);
    invDone = 1'b1; idle(NBLK + 2); invDone = 1'b0;
    sendReq(1, 0);                       // R3
    idle(NBLK + 2);
    sendReq(3, 0);                       // R4
    idle(2*NBLK + 2);
    wbDone = 1'b1; invDone = 1'b1; idle(2*NBLK + 2);
    wbDone = 1'b0; invDone = 1'b0;

    // randomised mix
    for (int c = 0; c < 6000; c++) begin
      reqValid = ($urandom_range(0, 1) == 1);
      reqKind  = 3'($urandom_range(0, 7));
      reqCtx   = CTX_W'($urandom_range(0, 15));
      cmdReady = ($urandom_range(0, 3) != 0);
      wbDone   = ($urandom_range(0, 9) < 3);
      invDone  = ($urandom_range(0, 9) < ((c % 1000 < 500) ? 1 : 4));
      step();
    end
    reqValid = 1'b0; wbDone = 1'b0; invDone = 1'b0; cmdReady = 1'b1;
    idle(4);

    finished = 1;
    summary();
    $finish;
  end

endmodule